// File: doc/BRIEF.md
# I2C Slave Register Bank

This block is an I2C-compatible slave. It lets a bus host read and write a small bank of 8-bit registers inside the chip. The block runs entirely on a fast system clock. It oversamples the SCL and SDA lines through synchronizers and finds their edges there. It drives SDA through an open-drain enable: when `sda_oe` is high, the line is pulled low.

The slave's 7-bit address is a fixed pattern plus one bit taken from a strap pin. A write transfer carries the address byte, then a starting register index, then data bytes. Each data byte goes to the next register in turn. A read transfer starts with a write of the index. The host then sends a repeated start and the address with the read flag, and the slave streams register contents until the host declines a byte. The lower registers are writable and appear on a parallel output bus. The upper registers return values taken from a parallel input bus.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The slave address is 7 bits: bit 6 = 1, bit 5 = `addr_strap_i`, bits 4..0 = 0. The first byte after a start is {address, rw}, with rw = 1 for a read. On a match the slave pulls SDA low during the ninth SCL pulse. On a mismatch it never drives SDA until the next start.
- R2: A start (SDA falls while SCL is high) at any point restarts address reception. A stop (SDA rises while SCL is high) at any point releases SDA and returns the slave to idle. A byte cut short by either event writes nothing.
- R3: Every byte, in either direction, travels most significant bit first.
- R4: In a write, the second byte sets the register index. Each following data byte is stored at the current index, acknowledged, and the index then advances by one.
- R5: An index byte of NREG (8) or more is not acknowledged, and the slave goes idle with no register changed.
- R6: After a write to the last register (index 7), further data bytes in the same transfer are neither acknowledged nor stored.
- R7: After a read address, the slave sends the register at the current index. After each byte the host acknowledges, the index advances, wrapping from 7 to 0.
- R8: When the host does not acknowledge a read byte, the slave releases SDA and does not drive it again until the next start.
- R9: The slave starts pulling SDA low only while SCL is low.
- R10: Registers 0..3 are writable; register i appears on `ctl_o[8i+7:8i]`. Registers 4..7 read `stat_i[8j+7:8j]` for register 4+j. Writes to registers 4..7 are acknowledged and have no effect.
- R11: After reset, SDA is released and `ctl_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| addr_strap_i | input | 1 | Sets bit 5 of the slave address |
| stat_i | input | 32 | Values returned for registers 4..7 |
| ctl_o | output | 32 | Contents of registers 0..3 |

## Verification
Two functions can fall in the same system cycle. One is the store of a completed data byte, together with the index advance, which happens on the SCL fall that ends the eighth bit. The other is the overflow flag that stops the next store. The bench provokes this with writes that start near the top index, so a burst runs past register 7. It checks that the acknowledge pattern and the stored values match a model that stops exactly at index 7. A second pairing is the read index advance against its wrap, judged by reading bursts that cross from 7 to 0. Aborts by start or stop placed inside a byte show that a byte cut short never reaches the bank.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RX,
      PH_RXACK,
      PH_TX,
      PH_TXACK
   } phase_t;

   typedef enum logic [1:0] {
      BY_ADDR,
      BY_SUB,
      BY_DATA
   } byte_kind_t;

   localparam int BYTE_W = 8;

   // 7-bit bus identity: fixed top bit, strapped second bit, low bits zero
   function automatic logic [6:0] slave_id(input logic strap);
      return {1'b1, strap, 5'b00000};
   endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_ff;
   logic [STAGES-1:0] sda_ff;
   logic              scl_q;
   logic              sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_lvl  = scl_ff[STAGES-1];
   assign sda_lvl  = sda_ff[STAGES-1];
   assign scl_rise = scl_lvl & ~scl_q;
   assign scl_fall = ~scl_lvl & scl_q;
   assign start_ev = scl_lvl & scl_q & sda_q & ~sda_lvl;
   assign stop_ev  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/i2c_reg_file.sv
module i2c_reg_file #(
   parameter int NREG = 8,
   parameter int NRW  = 4,
   parameter int AW   = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [AW-1:0]          waddr,
   input  logic [7:0]             wdata,
   input  logic [AW-1:0]          raddr,
   output logic [7:0]             rdata,
   input  logic [(NREG-NRW)*8-1:0] stat_i,
   output logic [NRW*8-1:0]       ctl_o
);
   logic [7:0] bank [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (g < NRW) begin : g_rw
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (we && waddr == AW'(g))
               q <= wdata;
         end
         assign bank[g]        = q;
         assign ctl_o[g*8 +: 8] = q;
      end else begin : g_ro
         assign bank[g] = stat_i[(g-NRW)*8 +: 8];
      end
   end

   assign rdata = bank[raddr];

   // R10
   ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr >= AW'(NRW)) |=> $stable(ctl_o));
endmodule

// File: rtl/i2c_proto_fsm.sv
module i2c_proto_fsm
   import i2c_rb_pkg::*;
#(
   parameter int NREG = 8,
   parameter int AW   = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_lvl,
   input  logic          sda_lvl,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          start_ev,
   input  logic          stop_ev,
   input  logic          strap,
   input  logic [7:0]    rdata,
   output logic          sda_oe,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [7:0]    wdata,
   output logic [AW-1:0] raddr
);
   localparam logic [AW-1:0] LAST = AW'(NREG - 1);

   phase_t       ph;
   byte_kind_t   kind;
   logic [3:0]   bitcnt;
   logic [7:0]   shreg;
   logic [AW-1:0] ptr;
   logic         ovf;
   logic         rw;
   logic         mack;
   logic         accept;
   logic         byte_done;

   assign byte_done = (ph == PH_RX) && scl_fall && (bitcnt == 4'd8);

   always_comb begin
      unique case (kind)
         BY_ADDR: accept = (shreg[7:1] == slave_id(strap));
         BY_SUB:  accept = ({1'b0, shreg} < 9'(NREG));
         default: accept = !ovf;
      endcase
   end

   assign we    = byte_done && (kind == BY_DATA) && !ovf;
   assign waddr = ptr;
   assign wdata = shreg;
   assign raddr = (ph == PH_TXACK) ? ptr + 1'b1 : ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         kind   <= BY_ADDR;
         bitcnt <= '0;
         shreg  <= '0;
         ptr    <= '0;
         ovf    <= 1'b0;
         rw     <= 1'b0;
         mack   <= 1'b0;
         sda_oe <= 1'b0;
      end else if (start_ev) begin
         ph     <= PH_RX;
         kind   <= BY_ADDR;
         bitcnt <= '0;
         sda_oe <= 1'b0;
      end else if (stop_ev) begin
         ph     <= PH_IDLE;
         bitcnt <= '0;
         sda_oe <= 1'b0;
      end else begin
         unique case (ph)
            PH_RX: begin
               if (scl_rise && bitcnt < 4'd8) begin
                  shreg  <= {shreg[6:0], sda_lvl};
                  bitcnt <= bitcnt + 4'd1;
               end else if (byte_done) begin
                  bitcnt <= '0;
                  if (accept) begin
                     sda_oe <= 1'b1;
                     ph     <= PH_RXACK;
                  end else begin
                     ph     <= PH_IDLE;
                  end
                  unique case (kind)
                     BY_ADDR: rw <= shreg[0];
                     BY_SUB: begin
                        ptr <= shreg[AW-1:0];
                        ovf <= 1'b0;
                     end
                     default: begin
                        if (accept) begin
                           if (ptr == LAST) ovf <= 1'b1;
                           else             ptr <= ptr + 1'b1;
                        end
                     end
                  endcase
               end
            end
            PH_RXACK: begin
               if (scl_fall) begin
                  bitcnt <= '0;
                  if (kind == BY_ADDR && rw) begin
                     ph     <= PH_TX;
                     shreg  <= rdata;
                     sda_oe <= ~rdata[7];
                  end else begin
                     ph     <= PH_RX;
                     sda_oe <= 1'b0;
                     kind   <= (kind == BY_ADDR) ? BY_SUB : BY_DATA;
                  end
               end
            end
            PH_TX: begin
               if (scl_rise) begin
                  bitcnt <= bitcnt + 4'd1;
               end else if (scl_fall) begin
                  if (bitcnt == 4'd8) begin
                     sda_oe <= 1'b0;
                     bitcnt <= '0;
                     ph     <= PH_TXACK;
                  end else begin
                     shreg  <= {shreg[6:0], 1'b0};
                     sda_oe <= ~shreg[6];
                  end
               end
            end
            PH_TXACK: begin
               if (scl_rise) begin
                  mack <= ~sda_lvl;
               end else if (scl_fall) begin
                  if (mack) begin
                     ptr    <= ptr + 1'b1;
                     shreg  <= rdata;
                     sda_oe <= ~rdata[7];
                     ph     <= PH_TX;
                  end else begin
                     ph     <= PH_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   // R9
   pull_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_lvl);

   // R2
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> (ph == PH_IDLE && !sda_oe));

   // R2
   start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> (ph == PH_RX && kind == BY_ADDR && bitcnt == 4'd0));

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_IDLE) |-> !sda_oe);

   // R6
   top_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && ptr == LAST) |=> ovf);

   // R3
   bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt <= 4'd8);
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
   parameter int NREG        = 8,
   parameter int NRW         = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    scl_i,
   input  logic                    sda_i,
   output logic                    sda_oe,
   input  logic                    addr_strap_i,
   input  logic [(NREG-NRW)*8-1:0] stat_i,
   output logic [NRW*8-1:0]        ctl_o
);
   localparam int AW = $clog2(NREG);

   if (NREG < 2 || NREG > 256 || (1 << AW) != NREG) begin : g_bad_nreg
      $error("i2c_regbank_slave: NREG must be a power of two in 2..256");
   end
   if (NRW < 1 || NRW >= NREG) begin : g_bad_nrw
      $error("i2c_regbank_slave: NRW must be in 1..NREG-1");
   end

   logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
   logic          we;
   logic [AW-1:0] waddr, raddr;
   logic [7:0]    wdata, rdata;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_lvl  (scl_lvl),
      .sda_lvl  (sda_lvl),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   i2c_proto_fsm #(.NREG(NREG), .AW(AW)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_lvl  (scl_lvl),
      .sda_lvl  (sda_lvl),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev),
      .strap    (addr_strap_i),
      .rdata    (rdata),
      .sda_oe   (sda_oe),
      .we       (we),
      .waddr    (waddr),
      .wdata    (wdata),
      .raddr    (raddr)
   );

   i2c_reg_file #(.NREG(NREG), .NRW(NRW), .AW(AW)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (we),
      .waddr  (waddr),
      .wdata  (wdata),
      .raddr  (raddr),
      .rdata  (rdata),
      .stat_i (stat_i),
      .ctl_o  (ctl_o)
   );
endmodule

// File: tb/sim_i2c_regbank_slave.sv
module sim_i2c_regbank_slave;
   localparam int Q = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        strap = 1'b0;
   logic [31:0] stat_v = 32'h0;
   logic        sda_oe;
   logic [31:0] ctl_o;
   logic        sda_line;

   int nvec = 0;
   int nbad = 0;
   int cyc  = 0;
   int r9_viol = 0;
   logic oe_prev = 1'b0;
   logic [7:0] model [4];

   assign sda_line = sda_m & ~sda_oe;

   i2c_regbank_slave u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (scl_m),
      .sda_i        (sda_line),
      .sda_oe       (sda_oe),
      .addr_strap_i (strap),
      .stat_i       (stat_v),
      .ctl_o        (ctl_o)
   );

   always #4 clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000) begin
         nbad++;
         $display("FAIL watchdog: run did not finish");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   // R9 monitor: a new pull-low must begin while the bench holds SCL low
   always @(negedge clk) begin
      if (rst_n && sda_oe && !oe_prev && scl_m) r9_viol++;
      oe_prev <= sda_oe;
   end

   function automatic logic [6:0] exp_addr(input logic s);
      return 7'h40 | (7'(s) << 5);
   endfunction

   function automatic logic [7:0] exp_reg(input int i);
      if (i < 4) return model[i];
      return stat_v[(i-4)*8 +: 8];
   endfunction

   function automatic logic [31:0] model_flat();
      return {model[3], model[2], model[1], model[0]};
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      sda_m = 1'b0; tick(2*Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      sda_m = 1'b1; tick(2*Q);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b;    tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      ack = ~sda_line;
      tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(Q);
         scl_m = 1'b1; tick(Q);
         b[i] = sda_line;
         tick(Q);
         scl_m = 1'b0; tick(Q);
      end
      sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
      sda_m = 1'b1;
   endtask

   // write burst: checks R1/R4/R5/R6/R10 against the model
   task automatic do_write(input int sub, input int n);
      bit a;
      logic [7:0] d;
      bus_start();
      send_byte({exp_addr(strap), 1'b0}, a);
      chk(a, "R1", "address ack (write)", int'(a), 1);
      send_byte(8'(sub), a);
      chk(a == (sub < 8), "R5", "index ack", int'(a), int'(sub < 8));
      if (sub < 8) begin
         for (int j = 0; j < n; j++) begin
            d = 8'($urandom);
            send_byte(d, a);
            if (sub + j <= 7) begin
               chk(a, "R4", "data ack", int'(a), 1);
               if (sub + j < 4) model[sub + j] = d;
            end else begin
               chk(!a, "R6", "ack past last register", int'(a), 0);
            end
         end
      end
      bus_stop();
      chk(ctl_o == model_flat(), (sub < 8) ? "R4" : "R5", "ctl_o after write",
          int'(ctl_o), int'(model_flat()));
   endtask

   // read burst: checks R7/R3 and the R8 release
   task automatic do_read(input int sub, input int n);
      bit a;
      logic [7:0] b;
      bus_start();
      send_byte({exp_addr(strap), 1'b0}, a);
      send_byte(8'(sub), a);
      bus_start();
      send_byte({exp_addr(strap), 1'b1}, a);
      chk(a, "R1", "address ack (read)", int'(a), 1);
      for (int j = 0; j < n; j++) begin
         recv_byte(j < n - 1, b);
         chk(b == exp_reg((sub + j) % 8), "R7", "read byte", int'(b),
             int'(exp_reg((sub + j) % 8)));
      end
      tick(Q);
      chk(!sda_oe, "R8", "SDA released after nack", int'(sda_oe), 0);
      bus_stop();
   endtask

   initial begin
      bit a;
      logic [7:0] b;
      logic [31:0] snap;
      void'($urandom(32'd7321));
      for (int i = 0; i < 4; i++) model[i] = 8'h00;
      stat_v = 32'hC3_5A_81_17;
      tick(5);
      // R11 reset state
      chk(!sda_oe, "R11", "sda_oe in reset", int'(sda_oe), 0);
      chk(ctl_o == 32'h0, "R11", "ctl_o in reset", int'(ctl_o), 0);
      rst_n = 1'b1;
      tick(5);
      chk(!sda_oe && ctl_o == 32'h0, "R11", "state after reset", int'(ctl_o), 0);

      // R3 R4: asymmetric bit patterns, then read back across all registers
      bus_start();
      send_byte({exp_addr(strap), 1'b0}, a);
      send_byte(8'h00, a);
      send_byte(8'h01, a); model[0] = 8'h01;
      send_byte(8'h80, a); model[1] = 8'h80;
      send_byte(8'hA5, a); model[2] = 8'hA5;
      send_byte(8'h3C, a); model[3] = 8'h3C;
      bus_stop();
      chk(ctl_o == 32'h3CA5_8001, "R3", "MSB-first store", int'(ctl_o), 32'h3CA58001);
      do_read(0, 8);

      // R1: other strap value, address must miss
      bus_start();
      send_byte({exp_addr(~strap), 1'b0}, a);
      chk(!a, "R1", "no ack on mismatch", int'(a), 0);
      send_byte(8'h00, a);
      chk(!a, "R1", "silent after mismatch", int'(a), 0);
      bus_stop();
      strap = 1'b1;
      do_write(1, 1);

      // R5: index out of range
      do_write(8, 2);
      do_write(255, 1);

      // R6 R10: burst from index 6 runs past the end; 6 and 7 are read-only
      do_write(6, 3);
      do_write(2, 4);
      chk(ctl_o == model_flat(), "R10", "read-only writes ignored",
          int'(ctl_o), int'(model_flat()));

      // R7: read wraps from 7 to 0
      do_read(6, 5);

      // R2: stop inside a data byte stores nothing
      snap = ctl_o;
      bus_start();
      send_byte({exp_addr(strap), 1'b0}, a);
      send_byte(8'h01, a);
      for (int i = 0; i < 4; i++) send_bit(1'b0);
      scl_m = 1'b0;
      bus_stop();
      chk(ctl_o == snap, "R2", "stop mid-byte", int'(ctl_o), int'(snap));
      chk(!sda_oe, "R2", "released after stop", int'(sda_oe), 0);

      // R2: start inside a data byte restarts address reception
      bus_start();
      send_byte({exp_addr(strap), 1'b0}, a);
      send_byte(8'h02, a);
      for (int i = 0; i < 3; i++) send_bit(1'b1);
      bus_start();
      send_byte({exp_addr(strap), 1'b0}, a);
      chk(a, "R2", "address after restart", int'(a), 1);
      send_byte(8'h02, a);
      send_byte(8'h5A, a);
      model[2] = 8'h5A;
      bus_stop();
      chk(ctl_o == model_flat(), "R2", "write after restart",
          int'(ctl_o), int'(model_flat()));

      // random mix
      for (int t = 0; t < 24; t++) begin
         int sub;
         strap  = 1'($urandom);
         stat_v = $urandom;
         if ($urandom % 2 == 0) begin
            sub = int'($urandom % 10);
            if (sub >= 8) sub = 8 + int'($urandom % 248);
            do_write(sub, 1 + int'($urandom % 4));
         end else begin
            do_read(int'($urandom % 8), 1 + int'($urandom % 9));
         end
      end

      chk(r9_viol == 0, "R9", "pull-low only while SCL low", r9_viol, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule